// File: doc/BRIEF.md
# ADC Acquisition Sequencer

This block drives an external parallel analog-to-digital converter and turns every sample into bytes on an outgoing valid/ready stream. A conversion is launched either by a command strobe or by a periodic timer tick, whichever source the control register selects. The end of a conversion is taken either from the converter's ready pin or from an internal trigger input, also chosen by the control register. An 8-bit address counter drives an external analog multiplexer. It starts from a programmed value and advances after each captured sample, so a bank of channels can be scanned in turn.

The sequencer is a five-state machine. From `ST_IDLE` (waiting for a start request), a request moves it to `ST_LAUNCH`. That state lasts one cycle and raises the convert-start pulse. `ST_LAUNCH` always moves on to `ST_WAIT`, where the machine waits for a completion event. A completion event reads and captures the sample, then moves to `ST_SEND_HI` for wide samples or to `ST_SEND_LO` for samples of 8 bits or fewer. `ST_SEND_HI` moves to `ST_SEND_LO` when its byte is accepted. `ST_SEND_LO` returns to `ST_IDLE` when its byte is accepted.

Three registers are written through a small port:
- address 0 (control): bit 0 selects the start source (0 command, 1 timer), bit 1 selects the completion source (0 ready pin, 1 internal trigger), and bits [11:8] hold the sample width minus one.
- address 1: the multiplexer start address, in bits [7:0].
- address 2: any write clears the overrun flag.

Top module: `adc_seq`

## Requirements
- R1: After reset, `conv_start`, `adc_rd`, `out_valid` and `overrun` are 0 and `mux_addr` is 0x00. The control register resets to command start, ready-pin completion and a width of 16 bits.
- R2: The start source follows control bit 0. If the selected source is high in `ST_IDLE`, `conv_start` is high for exactly one cycle, in the cycle after the request. The source that is not selected has no effect.
- R3: The completion source follows control bit 1 (0 = `adc_rdy`, 1 = `int_trig`). In `ST_WAIT`, `adc_rd` is high in the same cycle as the first event from the selected source, and the sample is captured at that clock edge. The completion source that is not selected has no effect.
- R4: The captured sample keeps bits 0 to W-1 of `adc_data`, where W is control bits [11:8] plus one. All higher bits read as zero.
- R5: When W is greater than 8, the sample is sent as two bytes, bits [15:8] first and then bits [7:0]. When W is 8 or less, only bits [7:0] are sent.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R7: `mux_addr` increases by one after each captured sample and wraps from 0xFF to 0x00.
- R8: A write to address 1 loads `mux_addr` at that clock edge. The load wins over an increment in the same cycle.
- R9: A start request from the selected source, seen outside `ST_IDLE`, is ignored and sets `overrun`. `overrun` stays set until a write to address 2 clears it.
- R10: No new conversion starts until the last byte of the previous sample has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 12 | Register write data |
| cmd_start | input | 1 | Command start strobe |
| tmr_tick | input | 1 | Periodic timer tick |
| adc_rdy | input | 1 | Converter ready pin |
| int_trig | input | 1 | Internal completion trigger |
| adc_data | input | 16 | Converter data bus |
| conv_start | output | 1 | Convert-start pulse |
| adc_rd | output | 1 | Converter read strobe |
| mux_addr | output | 8 | Analog multiplexer address |
| out_data | output | 8 | Outgoing sample byte |
| out_valid | output | 1 | Outgoing byte valid |
| out_ready | input | 1 | Outgoing byte accepted |
| overrun | output | 1 | Sticky ignored-request flag |

## Verification
The bench sweeps every sample width from 1 to 16 bits against several data patterns, cycling through all four start and completion source combinations. A wrong mask, or a wrong boundary between one-byte and two-byte output, would send extra or missing bytes or leak high bits. Every conversion first strobes the source that is not selected, so a swapped or ORed source select would show up as a false pulse or an early capture. The multiplexer address is taken across the 0xFF wrap and loaded in the same cycle as an increment; a design with the wrong priority would show the incremented address. Start requests are sent while the machine waits for completion and while it holds output bytes. A design that accepted them would pulse `conv_start` early, and one that did not latch the overrun would lose the flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_SEND_HI,
        ST_SEND_LO
    } seq_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_MUX  = 2'd1;
    localparam logic [1:0] REG_CLR  = 2'd2;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
    parameter int DATA_W = 16,
    parameter int MUX_W  = 8,
    localparam int WSEL_W = $clog2(DATA_W),
    localparam int CFG_W  = 8 + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              timer_start,
    output logic              int_done,
    output logic [WSEL_W-1:0] width_m1,
    output logic              mux_load,
    output logic [MUX_W-1:0]  mux_load_val,
    output logic              ovr_clr
);
    import adc_seq_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_start <= 1'b0;
            int_done    <= 1'b0;
            width_m1    <= WSEL_W'(DATA_W - 1);
        end else if (cfg_we && cfg_addr == REG_CTRL) begin
            timer_start <= cfg_wdata[0];
            int_done    <= cfg_wdata[1];
            width_m1    <= cfg_wdata[8 +: WSEL_W];
        end
    end

    always_comb begin
        mux_load     = cfg_we && (cfg_addr == REG_MUX);
        mux_load_val = cfg_wdata[MUX_W-1:0];
        ovr_clr      = cfg_we && (cfg_addr == REG_CLR);
    end

endmodule

// File: rtl/adc_seq_mux.sv
module adc_seq_mux #(
    parameter int MUX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MUX_W-1:0] load_val,
    input  logic             advance,
    output logic [MUX_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (advance)
            addr <= addr + MUX_W'(1);
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
    parameter int DATA_W = 16,
    localparam int WSEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timer_start,
    input  logic              int_done,
    input  logic [WSEL_W-1:0] width_m1,
    input  logic              ovr_clr,
    input  logic              cmd_start,
    input  logic              tmr_tick,
    input  logic              adc_rdy,
    input  logic              int_trig,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              out_ready,
    output logic              conv_start,
    output logic              adc_rd,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              overrun
);
    import adc_seq_pkg::*;

    seq_state_t        state, state_nx;
    logic              start_req, done_evt, narrow;
    logic [DATA_W-1:0] mask, sample;
    logic [15:0]       sample16;

    always_comb begin
        start_req = timer_start ? tmr_tick : cmd_start;
        done_evt  = int_done ? int_trig : adc_rdy;
        narrow    = (int'(width_m1) < 8);
        for (int i = 0; i < DATA_W; i++)
            mask[i] = (i <= int'(width_m1));
        sample16  = 16'(sample);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_req) state_nx = ST_LAUNCH;
            ST_LAUNCH:  state_nx = ST_WAIT;
            ST_WAIT:    if (done_evt) state_nx = narrow ? ST_SEND_LO : ST_SEND_HI;
            ST_SEND_HI: if (out_ready) state_nx = ST_SEND_LO;
            ST_SEND_LO: if (out_ready) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_start = 1'b0;
        adc_rd     = 1'b0;
        out_valid  = 1'b0;
        out_data   = 8'h00;
        unique case (state)
            ST_IDLE:    ;
            ST_LAUNCH:  conv_start = 1'b1;
            ST_WAIT:    adc_rd = done_evt;
            ST_SEND_HI: begin out_valid = 1'b1; out_data = sample16[15:8]; end
            ST_SEND_LO: begin out_valid = 1'b1; out_data = sample16[7:0];  end
            default:    ;
        endcase
    end

    // sample capture and sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample  <= '0;
            overrun <= 1'b0;
        end else begin
            if (state == ST_WAIT && done_evt)
                sample <= adc_data & mask;
            if (start_req && state != ST_IDLE)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int DATA_W = 16,
    parameter int MUX_W  = 8,
    localparam int WSEL_W = $clog2(DATA_W),
    localparam int CFG_W  = 8 + WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmd_start,
    input  logic              tmr_tick,
    input  logic              adc_rdy,
    input  logic              int_trig,
    input  logic [DATA_W-1:0] adc_data,
    output logic              conv_start,
    output logic              adc_rd,
    output logic [MUX_W-1:0]  mux_addr,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              overrun
);

    logic              timer_start, int_done, mux_load, ovr_clr;
    logic [WSEL_W-1:0] width_m1;
    logic [MUX_W-1:0]  mux_load_val;

    adc_seq_cfg #(.DATA_W(DATA_W), .MUX_W(MUX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .timer_start(timer_start), .int_done(int_done),
        .width_m1(width_m1), .mux_load(mux_load), .mux_load_val(mux_load_val),
        .ovr_clr(ovr_clr)
    );

    adc_seq_mux #(.MUX_W(MUX_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .load(mux_load), .load_val(mux_load_val),
        .advance(adc_rd), .addr(mux_addr)
    );

    adc_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .timer_start(timer_start), .int_done(int_done),
        .width_m1(width_m1), .ovr_clr(ovr_clr), .cmd_start(cmd_start),
        .tmr_tick(tmr_tick), .adc_rdy(adc_rdy), .int_trig(int_trig),
        .adc_data(adc_data), .out_ready(out_ready), .conv_start(conv_start),
        .adc_rd(adc_rd), .out_data(out_data), .out_valid(out_valid),
        .overrun(overrun)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int MUX_W = 8,
    parameter int CFG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             conv_start,
    input logic             adc_rd,
    input logic [MUX_W-1:0] mux_addr,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             overrun
);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_rd_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd |-> (!conv_start && !out_valid));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_mux_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_rd && !(cfg_we && cfg_addr == 2'd1)) |=> (mux_addr == $past(mux_addr) + MUX_W'(1)));

    assert_mux_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd1) |=> (mux_addr == $past(cfg_wdata[MUX_W-1:0])));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(cfg_we && cfg_addr == 2'd2)) |=> overrun);

    assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !conv_start);

endmodule

bind adc_seq adc_seq_chk #(.MUX_W(MUX_W), .CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .conv_start(conv_start), .adc_rd(adc_rd),
    .mux_addr(mux_addr), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .overrun(overrun)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [11:0] cfg_wdata = 12'd0;
    logic        cmd_start = 1'b0, tmr_tick = 1'b0, adc_rdy = 1'b0, int_trig = 1'b0;
    logic [15:0] adc_data = 16'd0;
    logic        out_ready = 1'b0;
    logic        conv_start, adc_rd, out_valid, overrun;
    logic [7:0]  mux_addr, out_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_mux = 8'h00;

    always #2.5 clk = ~clk;

    adc_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_start(cmd_start), .tmr_tick(tmr_tick),
        .adc_rdy(adc_rdy), .int_trig(int_trig), .adc_data(adc_data),
        .conv_start(conv_start), .adc_rd(adc_rd), .mux_addr(mux_addr),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .overrun(overrun)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic conv(input bit tmr, input bit intd, input logic [15:0] d, input int wm1);
        logic [16:0] mask;
        logic [15:0] m;
        mask = (17'd1 << (wm1 + 1)) - 17'd1;
        m = d & mask[15:0];
        // unselected start source (R2)
        if (tmr) cmd_start = 1'b1; else tmr_tick = 1'b1;
        step();
        cmd_start = 1'b0; tmr_tick = 1'b0;
        chk(conv_start == 1'b0, "R2 unselected start", int'(conv_start), 0);
        // selected start source
        if (tmr) tmr_tick = 1'b1; else cmd_start = 1'b1;
        step();
        cmd_start = 1'b0; tmr_tick = 1'b0;
        chk(conv_start == 1'b1, "R2 start pulse", int'(conv_start), 1);
        step();
        chk(conv_start == 1'b0, "R2 pulse width", int'(conv_start), 0);
        // unselected completion (R3)
        adc_data = d;
        if (intd) adc_rdy = 1'b1; else int_trig = 1'b1;
        #0.5;
        chk(adc_rd == 1'b0, "R3 unselected done rd", int'(adc_rd), 0);
        step();
        adc_rdy = 1'b0; int_trig = 1'b0;
        chk(out_valid == 1'b0, "R3 unselected done", int'(out_valid), 0);
        // selected completion
        if (intd) int_trig = 1'b1; else adc_rdy = 1'b1;
        #0.5;
        chk(adc_rd == 1'b1, "R3 read strobe", int'(adc_rd), 1);
        step();
        adc_rdy = 1'b0; int_trig = 1'b0;
        adc_data = ~d;
        exp_mux = exp_mux + 8'd1;
        chk(mux_addr == exp_mux, "R7 mux step", int'(mux_addr), int'(exp_mux));
        if (wm1 >= 8) begin
            chk(out_valid && out_data == m[15:8], "R4 R5 high byte", int'(out_data), int'(m[15:8]));
            step();
            chk(out_valid && out_data == m[15:8], "R6 hold", int'(out_data), int'(m[15:8]));
            out_ready = 1'b1;
            step();
            chk(out_valid && out_data == m[7:0], "R5 low byte", int'(out_data), int'(m[7:0]));
            step();
        end else begin
            chk(out_valid && out_data == m[7:0], "R4 R5 single byte", int'(out_data), int'(m[7:0]));
            step();
            chk(out_valid && out_data == m[7:0], "R6 hold", int'(out_data), int'(m[7:0]));
            out_ready = 1'b1;
            step();
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R5 byte count", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) step();
        chk(conv_start == 0 && adc_rd == 0 && out_valid == 0, "R1 outputs", int'({conv_start, adc_rd, out_valid}), 0);
        chk(mux_addr == 8'h00, "R1 mux", int'(mux_addr), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        step();
        // default config: command start, pin completion, 16 bits (R1)
        conv(1'b0, 1'b0, 16'hBEEF, 15);

        wr(2'd1, 12'h0FE);
        exp_mux = 8'hFE;
        chk(mux_addr == 8'hFE, "R8 load", int'(mux_addr), 8'hFE);

        // near-exhaustive sweep over widths, patterns and source modes
        for (int w = 0; w < 16; w++) begin
            for (int p = 0; p < 3; p++) begin
                bit tm, idn;
                logic [15:0] d;
                tm  = ((w + p) % 2) == 1;
                idn = (((w + p) / 2) % 2) == 1;
                d = (p == 0) ? 16'hFFFF : (p == 1) ? 16'hA5C3 : (16'h1234 ^ (16'(w) * 16'h0111));
                wr(2'd0, 12'(w << 8) | 12'(idn << 1) | 12'(tm));
                conv(tm, idn, d, w);
            end
        end

        // overrun and busy-ignore: command, pin, 16 bits
        wr(2'd0, 12'hF00);
        cmd_start = 1'b1; step(); cmd_start = 1'b0;
        step();
        cmd_start = 1'b1; step(); cmd_start = 1'b0;
        chk(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
        chk(conv_start == 1'b0, "R9 ignored in wait", int'(conv_start), 0);
        // load wins over increment (R8)
        adc_rdy = 1'b1; adc_data = 16'h1357;
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 12'h033;
        step();
        cfg_we = 1'b0; adc_rdy = 1'b0;
        exp_mux = 8'h33;
        chk(mux_addr == 8'h33, "R8 precedence", int'(mux_addr), 8'h33);
        cmd_start = 1'b1; step(); cmd_start = 1'b0;
        chk(conv_start == 1'b0 && out_valid, "R10 ignored while sending", int'(conv_start), 0);
        chk(out_data == 8'h13, "R10 byte kept", int'(out_data), 8'h13);
        out_ready = 1'b1; step(); step(); out_ready = 1'b0;
        step();
        chk(conv_start == 1'b0, "R10 no late start", int'(conv_start), 0);
        chk(overrun == 1'b1, "R9 sticky", int'(overrun), 1);
        wr(2'd2, 12'h000);
        chk(overrun == 1'b0, "R9 clear", int'(overrun), 0);
        conv(1'b0, 1'b0, 16'h0F0F, 15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule